// File: doc/BRIEF.md
# Multi-Locality Register Window Decoder

This block sits behind a memory-mapped slave port and turns each aligned 1-, 2- or 4-byte access into a decoded register operation. The address space is split into equal windows, one per locality. The high offset bits give the locality number and the low bits give the register offset inside that window. Identification, capability, revision and interrupt-vector registers are answered locally from parameters. Access-control, interrupt, status and data-FIFO registers are forwarded to downstream arbitration and interrupt logic. Reads use a combinational select/return pair, and writes use a registered strobe carrying lane-steered data and byte enables.

Registers that only the active locality may touch are gated here. A write from any other locality is dropped. A status read from any other locality returns all ones. The active locality is supplied by the downstream arbiter. Each accepted request gets one registered response in the following cycle. That response carries read data or an error flag for a malformed access.

Top module: `locwin_decoder`

## Requirements
- R1: The locality is `req_addr[14:12]` and the window offset is `req_addr[11:0]`; `dn_loc` and `dn_reg` show the decode of the current request combinationally. A locality of 5, 6 or 7 maps nothing: reads return all ones and writes raise no strobe.
- R2: At any mapped locality, a 4-byte read returns a constant for four offsets. Offset 0x14 returns 0x20000697, the capability word: interrupt support bits 0, 1, 2, 4 and 7, transfer-size code 3 in bits 10:9, and interface code 2 in bits 30:28. Offset 0xF00 returns {device 0x0001, vendor 0x1014} = 0x00011014. Offset 0xF04 returns 0x00000001. Offset 0x0C returns the IRQ number, 10.
- R3: A read of a word offset that is not one of 0x00, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x24, 0x80, 0xF00 or 0xF04 returns all ones. A write to such an offset raises no strobe.
- R4: A status read (0x18) from a locality that is not active returns all ones. A locality is active when `act_valid` is 1 and `act_loc` equals it. A status read from the active locality returns `dn_rdata`. Reads of 0x00, 0x08, 0x10, 0x24 and 0x80 return `dn_rdata` whatever the active locality.
- R5: Writes to the following offsets raise `wr_valid` only when the locality is active:

  | Offset | Register | `wr_reg` code |
  |---|---|---|
  | 0x08 | interrupt enable | 2 |
  | 0x10 | interrupt status | 3 |
  | 0x18 | status | 4 |
  | 0x24 | data FIFO | 5 |
  | 0x80 | extended FIFO | 6 |

  From any other locality these writes are dropped.
- R6: A write to 0x00 raises `wr_valid` with `wr_reg` = 1 from any mapped locality, and `wr_loc` gives that locality. Writes to 0x0C, 0x14, 0xF00 and 0xF04 never raise `wr_valid`.
- R7: `req_size` 0 selects a byte, 1 a halfword and 2 a word. A narrow read returns the addressed lanes of the register, selected by `req_addr[1:0]`, shifted down to bit 0 and zero-extended.
- R8: A write places `req_wdata` on the addressed lanes of `wr_data` (shifted left by 8 × `req_addr[1:0]`). `wr_be` marks exactly the lanes covered: one bit for a byte, two for a halfword, all four for a word.
- R9: A misaligned access (`req_size` 3, a word with `req_addr[1:0]` ≠ 0, or a halfword with `req_addr[0]` = 1) sets `rsp_err`, returns all ones and raises no strobe.
- R10: After reset `rsp_valid` and `wr_valid` are 0, and `req_ready` is 1 from the first clock after reset. `rsp_valid` is 1 in exactly the cycle after an accepted request, and `wr_valid` appears in that same cycle. A successful write returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte offset into the register space |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Misaligned or invalid access |
| rsp_rdata | output | 32 | Read data, right-aligned |
| act_valid | input | 1 | A locality currently holds the device |
| act_loc | input | 3 | Number of the active locality |
| dn_loc | output | 3 | Locality of the current request |
| dn_reg | output | 4 | Register code of the current request |
| dn_rdata | input | 32 | Downstream word for dn_loc/dn_reg, same cycle |
| wr_valid | output | 1 | Write strobe to downstream |
| wr_loc | output | 3 | Locality of the strobed write |
| wr_reg | output | 4 | Register code of the strobed write |
| wr_data | output | 32 | Lane-steered write data |
| wr_be | output | 4 | Byte enables of the strobed write |

## Verification
The hardest case to reach is the same register offset behaving two ways. The status and gated write offsets must be reached from an active locality, from an inactive one, and with no locality active at all. The response must also fall exactly one cycle after each request. A vector table steps `act_valid` and `act_loc` against the address of every request, so the same offset is driven from more than one locality in back-to-back cycles. Narrow accesses are aimed at the upper lanes of constant registers, which exposes the lane steering, and misaligned requests are aimed at offsets that would otherwise be writable.

// File: rtl/locwin_pkg.sv
package locwin_pkg;

   // Register codes seen by downstream logic on dn_reg / wr_reg
   typedef enum logic [3:0] {
      RC_NONE   = 4'd0,
      RC_ACCESS = 4'd1,
      RC_INTEN  = 4'd2,
      RC_INTSTS = 4'd3,
      RC_STATUS = 4'd4,
      RC_FIFO   = 4'd5,
      RC_XFIFO  = 4'd6,
      RC_VEC    = 4'd8,
      RC_CAP    = 4'd9,
      RC_ID     = 4'd10,
      RC_REV    = 4'd11
   } regcode_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   // Capability word fields
   localparam logic [31:0] CAP_IRQ_AVAIL  = 32'h1 << 0;
   localparam logic [31:0] CAP_IRQ_VALID  = 32'h1 << 1;
   localparam logic [31:0] CAP_IRQ_LOCCHG = 32'h1 << 2;
   localparam logic [31:0] CAP_LVL_LOW    = 32'h1 << 4;
   localparam logic [31:0] CAP_IRQ_READY  = 32'h1 << 7;
   localparam logic [31:0] CAP_XFER_64    = 32'd3 << 9;
   localparam logic [31:0] CAP_IFACE_V2   = 32'd2 << 28;
   localparam logic [31:0] CAP_WORD = CAP_IRQ_AVAIL | CAP_IRQ_VALID | CAP_IRQ_LOCCHG
                                    | CAP_LVL_LOW | CAP_IRQ_READY | CAP_XFER_64
                                    | CAP_IFACE_V2;

   function automatic logic owner_only(regcode_e c);
      return (c == RC_INTEN) || (c == RC_INTSTS) || (c == RC_STATUS)
          || (c == RC_FIFO) || (c == RC_XFIFO);
   endfunction

endpackage

// File: rtl/locwin_addr_split.sv
module locwin_addr_split import locwin_pkg::*; #(
   parameter int ADDR_W    = 15,
   parameter int NUM_LOC   = 5,
   parameter int WIN_BYTES = 4096,
   localparam int WIN_W    = $clog2(WIN_BYTES),
   localparam int LOC_W    = ADDR_W - WIN_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic [LOC_W-1:0]  loc,
   output logic              loc_ok,
   output regcode_e          code,
   output logic [1:0]        lane,
   output logic              misalign
);

   logic       hi_zero;
   logic [9:0] woff;

   assign loc    = addr[ADDR_W-1:WIN_W];
   assign loc_ok = int'(loc) < NUM_LOC;
   assign lane   = addr[1:0];
   assign woff   = addr[11:2];

   // windows wider than the decoded 4 KiB leave their upper part unmapped
   generate
      if (WIN_W > 12) begin : g_wide
         assign hi_zero = ~|addr[WIN_W-1:12];
      end else begin : g_exact
         assign hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      code = RC_NONE;
      if (hi_zero) begin
         case (woff)
            10'h000: code = RC_ACCESS;
            10'h002: code = RC_INTEN;
            10'h003: code = RC_VEC;
            10'h004: code = RC_INTSTS;
            10'h005: code = RC_CAP;
            10'h006: code = RC_STATUS;
            10'h009: code = RC_FIFO;
            10'h020: code = RC_XFIFO;
            10'h3C0: code = RC_ID;
            10'h3C1: code = RC_REV;
            default: code = RC_NONE;
         endcase
      end
   end

   always_comb begin
      case (size)
         SZ_BYTE: misalign = 1'b0;
         SZ_HALF: misalign = addr[0];
         SZ_WORD: misalign = |addr[1:0];
         default: misalign = 1'b1;
      endcase
   end

endmodule

// File: rtl/locwin_rd_mux.sv
module locwin_rd_mux import locwin_pkg::*; #(
   parameter logic [15:0] VEN_ID  = 16'h1014,
   parameter logic [15:0] DEV_ID  = 16'h0001,
   parameter logic [7:0]  REV_ID  = 8'h01,
   parameter int          IRQ_NUM = 10
) (
   input  regcode_e    code,
   input  logic        loc_ok,
   input  logic        active,
   input  logic        misalign,
   input  logic [1:0]  lane,
   input  logic [1:0]  size,
   input  logic [31:0] dn_rdata,
   output logic [31:0] rdata
);

   logic [31:0] word;
   logic [31:0] steered;

   always_comb begin
      word = '1;
      if (loc_ok) begin
         case (code)
            RC_ACCESS, RC_INTEN, RC_INTSTS,
            RC_FIFO, RC_XFIFO: word = dn_rdata;
            RC_STATUS:         word = active ? dn_rdata : '1;
            RC_VEC:            word = 32'(IRQ_NUM);
            RC_CAP:            word = CAP_WORD;
            RC_ID:             word = {DEV_ID, VEN_ID};
            RC_REV:            word = {24'h0, REV_ID};
            default:           word = '1;
         endcase
      end
   end

   always_comb begin
      steered = word >> {lane, 3'b000};
      case (size)
         SZ_BYTE: rdata = {24'h0, steered[7:0]};
         SZ_HALF: rdata = {16'h0, steered[15:0]};
         default: rdata = steered;
      endcase
      if (misalign) rdata = '1;
   end

endmodule

// File: rtl/locwin_wr_gate.sv
module locwin_wr_gate import locwin_pkg::*; #(
   parameter int LANES = 4
) (
   input  logic             write,
   input  regcode_e         code,
   input  logic             loc_ok,
   input  logic             active,
   input  logic             misalign,
   input  logic [1:0]       lane,
   input  logic [1:0]       size,
   input  logic [31:0]      wdata,
   output logic             wr_en,
   output logic [31:0]      wdata_lane,
   output logic [LANES-1:0] be
);

   logic allowed;

   assign allowed    = loc_ok && !misalign
                    && ((code == RC_ACCESS) || (owner_only(code) && active));
   assign wr_en      = write && allowed;
   assign wdata_lane = wdata << {lane, 3'b000};

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         localparam logic [1:0] LN = 2'(i);
         always_comb begin
            case (size)
               SZ_BYTE: be[i] = (lane == LN);
               SZ_HALF: be[i] = (lane[1] == LN[1]);
               default: be[i] = 1'b1;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/locwin_decoder.sv
module locwin_decoder import locwin_pkg::*; #(
   parameter int          ADDR_W    = 15,
   parameter int          NUM_LOC   = 5,
   parameter int          WIN_BYTES = 4096,
   parameter logic [15:0] VEN_ID    = 16'h1014,
   parameter logic [15:0] DEV_ID    = 16'h0001,
   parameter logic [7:0]  REV_ID    = 8'h01,
   parameter int          IRQ_NUM   = 10,
   localparam int         WIN_W     = $clog2(WIN_BYTES),
   localparam int         LOC_W     = ADDR_W - WIN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   input  logic              act_valid,
   input  logic [LOC_W-1:0]  act_loc,
   output logic [LOC_W-1:0]  dn_loc,
   output logic [3:0]        dn_reg,
   input  logic [31:0]       dn_rdata,
   output logic              wr_valid,
   output logic [LOC_W-1:0]  wr_loc,
   output logic [3:0]        wr_reg,
   output logic [31:0]       wr_data,
   output logic [3:0]        wr_be
);

   // elaboration-time parameter checks
   generate
      if ((1 << WIN_W) != WIN_BYTES || WIN_W < 12) begin : g_bad_win
         $error("WIN_BYTES must be a power of two of at least 4096");
      end
      if (LOC_W < 1 || NUM_LOC < 1 || NUM_LOC > (1 << LOC_W)) begin : g_bad_loc
         $error("NUM_LOC does not fit the locality field");
      end
      if (IRQ_NUM < 0 || IRQ_NUM > 255) begin : g_bad_irq
         $error("IRQ_NUM out of range");
      end
   endgenerate

   logic [LOC_W-1:0] loc;
   logic             loc_ok;
   regcode_e         code;
   logic [1:0]       lane;
   logic             misalign;
   logic             active;
   logic [31:0]      rd_word;
   logic             wr_en;
   logic [31:0]      wdata_lane;
   logic [3:0]       be;
   logic             fire;

   locwin_addr_split #(.ADDR_W(ADDR_W), .NUM_LOC(NUM_LOC), .WIN_BYTES(WIN_BYTES)) u_split (
      .addr(req_addr), .size(req_size), .loc(loc), .loc_ok(loc_ok),
      .code(code), .lane(lane), .misalign(misalign)
   );

   assign active = act_valid && (act_loc == loc);
   assign dn_loc = loc;
   assign dn_reg = code;
   assign fire   = req_valid && req_ready;

   locwin_rd_mux #(.VEN_ID(VEN_ID), .DEV_ID(DEV_ID), .REV_ID(REV_ID), .IRQ_NUM(IRQ_NUM)) u_rd (
      .code(code), .loc_ok(loc_ok), .active(active), .misalign(misalign),
      .lane(lane), .size(req_size), .dn_rdata(dn_rdata), .rdata(rd_word)
   );

   locwin_wr_gate #(.LANES(4)) u_wr (
      .write(req_write), .code(code), .loc_ok(loc_ok), .active(active),
      .misalign(misalign), .lane(lane), .size(req_size), .wdata(req_wdata),
      .wr_en(wr_en), .wdata_lane(wdata_lane), .be(be)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_ready <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
         wr_valid  <= 1'b0;
         wr_loc    <= '0;
         wr_reg    <= '0;
         wr_data   <= '0;
         wr_be     <= '0;
      end else begin
         req_ready <= 1'b1;
         rsp_valid <= fire;
         wr_valid  <= fire && wr_en;
         if (fire) begin
            rsp_err   <= misalign;
            rsp_rdata <= req_write ? (misalign ? '1 : '0) : rd_word;
         end
         if (fire && wr_en) begin
            wr_loc  <= loc;
            wr_reg  <= code;
            wr_data <= wdata_lane;
            wr_be   <= be;
         end
      end
   end

   assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rsp_valid);
   assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !rsp_valid && !wr_valid);
   assert_misalign_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fire && misalign |=> rsp_err && !wr_valid && (rsp_rdata == 32'hFFFF_FFFF));
   assert_gate_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire && req_write && owner_only(code) && !active |=> !wr_valid);
   assert_unmapped_loc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !loc_ok |=> !wr_valid);
   assert_status_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !req_write && (code == RC_STATUS) && !active && (req_size == SZ_WORD)
      |=> rsp_rdata == 32'hFFFF_FFFF);
   assert_be_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ($countones(wr_be) == 1 || $countones(wr_be) == 2 || wr_be == 4'hF));

endmodule

// File: tb/sim_locwin_decoder.sv
`timescale 1ns/1ps
module sim_locwin_decoder;

   typedef struct packed {
      logic        wr;
      logic [1:0]  sz;
      logic [14:0] ad;
      logic [31:0] wd;
      logic        av;
      logic [2:0]  al;
      logic [31:0] erd;
      logic        eerr;
      logic        ewv;
      logic [3:0]  ereg;
      logic [31:0] ewd;
      logic [3:0]  ebe;
      logic [3:0]  rq;
   } vec_t;

   localparam logic [31:0] ONES = 32'hFFFF_FFFF;
   localparam int N_VEC = 33;
   localparam vec_t TBL [N_VEC] = '{
      '{1'b0, 2'd2, 15'h0014, 32'h0, 1'b1, 3'd1, 32'h20000697, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd2},  // R2 cap
      '{1'b0, 2'd2, 15'h4F00, 32'h0, 1'b1, 3'd1, 32'h00011014, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd2},  // R2 id
      '{1'b0, 2'd2, 15'h2F04, 32'h0, 1'b1, 3'd1, 32'h00000001, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd2},  // R2 rev
      '{1'b0, 2'd2, 15'h300C, 32'h0, 1'b1, 3'd1, 32'h0000000A, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd2},  // R2 vector
      '{1'b0, 2'd2, 15'h0004, 32'h0, 1'b1, 3'd1, ONES,         1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd3},  // R3
      '{1'b0, 2'd2, 15'h1FFC, 32'h0, 1'b1, 3'd1, ONES,         1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd3},  // R3
      '{1'b0, 2'd2, 15'h1018, 32'h0, 1'b1, 3'd1, 32'hC0DE0401, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd4},  // R4 active
      '{1'b0, 2'd2, 15'h2018, 32'h0, 1'b1, 3'd1, ONES,         1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd4},  // R4 other
      '{1'b0, 2'd2, 15'h3018, 32'h0, 1'b0, 3'd3, ONES,         1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd4},  // R4 none
      '{1'b0, 2'd2, 15'h2008, 32'h0, 1'b1, 3'd1, 32'hC0DE0202, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd4},  // R4 ungated
      '{1'b0, 2'd2, 15'h5014, 32'h0, 1'b1, 3'd1, ONES,         1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd1},  // R1
      '{1'b0, 2'd2, 15'h7F00, 32'h0, 1'b1, 3'd1, ONES,         1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd1},  // R1
      '{1'b0, 2'd0, 15'h0015, 32'h0, 1'b1, 3'd1, 32'h00000006, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd7},  // R7
      '{1'b0, 2'd0, 15'h0017, 32'h0, 1'b1, 3'd1, 32'h00000020, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd7},  // R7
      '{1'b0, 2'd1, 15'h0016, 32'h0, 1'b1, 3'd1, 32'h00002000, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd7},  // R7
      '{1'b0, 2'd1, 15'h4F02, 32'h0, 1'b1, 3'd1, 32'h00000001, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd7},  // R7
      '{1'b0, 2'd0, 15'h1019, 32'h0, 1'b1, 3'd1, 32'h00000004, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd7},  // R7
      '{1'b0, 2'd2, 15'h0016, 32'h0, 1'b1, 3'd1, ONES,         1'b1, 1'b0, 4'd0, 32'h0, 4'h0, 4'd9},  // R9
      '{1'b0, 2'd1, 15'h0015, 32'h0, 1'b1, 3'd1, ONES,         1'b1, 1'b0, 4'd0, 32'h0, 4'h0, 4'd9},  // R9
      '{1'b0, 2'd3, 15'h0014, 32'h0, 1'b1, 3'd1, ONES,         1'b1, 1'b0, 4'd0, 32'h0, 4'h0, 4'd9},  // R9
      '{1'b1, 2'd2, 15'h1008, 32'h12345678, 1'b1, 3'd1, 32'h0, 1'b0, 1'b1, 4'd2, 32'h12345678, 4'hF, 4'd5},  // R5
      '{1'b1, 2'd2, 15'h2008, 32'h12345678, 1'b1, 3'd1, 32'h0, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd5},  // R5
      '{1'b1, 2'd2, 15'h0018, 32'h00000001, 1'b0, 3'd0, 32'h0, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd5},  // R5
      '{1'b1, 2'd2, 15'h1080, 32'hCAFEF00D, 1'b1, 3'd1, 32'h0, 1'b0, 1'b1, 4'd6, 32'hCAFEF00D, 4'hF, 4'd5},  // R5
      '{1'b1, 2'd2, 15'h3000, 32'h00000002, 1'b1, 3'd1, 32'h0, 1'b0, 1'b1, 4'd1, 32'h00000002, 4'hF, 4'd6},  // R6
      '{1'b1, 2'd2, 15'h000C, 32'h00000005, 1'b1, 3'd0, 32'h0, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd6},  // R6
      '{1'b1, 2'd2, 15'h0F00, 32'h00000005, 1'b1, 3'd0, 32'h0, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd6},  // R6
      '{1'b1, 2'd2, 15'h1004, 32'h00000005, 1'b1, 3'd1, 32'h0, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd3},  // R3
      '{1'b1, 2'd2, 15'h5008, 32'h00000005, 1'b1, 3'd5, 32'h0, 1'b0, 1'b0, 4'd0, 32'h0, 4'h0, 4'd1},  // R1
      '{1'b1, 2'd0, 15'h1026, 32'h000000AB, 1'b1, 3'd1, 32'h0, 1'b0, 1'b1, 4'd5, 32'h00AB0000, 4'b0100, 4'd8},  // R8
      '{1'b1, 2'd1, 15'h1012, 32'h0000BEEF, 1'b1, 3'd1, 32'h0, 1'b0, 1'b1, 4'd3, 32'hBEEF0000, 4'b1100, 4'd8},  // R8
      '{1'b1, 2'd0, 15'h1019, 32'h00000040, 1'b1, 3'd1, 32'h0, 1'b0, 1'b1, 4'd4, 32'h00004000, 4'b0010, 4'd8},  // R8
      '{1'b1, 2'd1, 15'h1011, 32'h0000BEEF, 1'b1, 3'd1, ONES,  1'b1, 1'b0, 4'd0, 32'h0, 4'h0, 4'd9}   // R9
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        act_valid = 1'b0;
   logic [2:0]  act_loc = '0;
   logic [2:0]  dn_loc;
   logic [3:0]  dn_reg;
   logic [31:0] dn_rdata;
   logic        wr_valid;
   logic [2:0]  wr_loc;
   logic [3:0]  wr_reg;
   logic [31:0] wr_data;
   logic [3:0]  wr_be;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   // downstream model: word depends on requested locality and register code
   assign dn_rdata = 32'hC0DE_0000 | {20'h0, dn_reg, 8'h00} | {29'h0, dn_loc};

   locwin_decoder u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .act_valid(act_valid), .act_loc(act_loc),
      .dn_loc(dn_loc), .dn_reg(dn_reg), .dn_rdata(dn_rdata),
      .wr_valid(wr_valid), .wr_loc(wr_loc), .wr_reg(wr_reg),
      .wr_data(wr_data), .wr_be(wr_be)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", what, act, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset rsp_valid", 32'(rsp_valid), 32'h0);
      chk("R10 reset wr_valid", 32'(wr_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 ready after reset", 32'(req_ready), 32'h1);

      // table walk, one request per cycle
      req_valid = 1'b1;
      for (int i = 0; i < N_VEC; i++) begin
         req_write = TBL[i].wr;
         req_size  = TBL[i].sz;
         req_addr  = TBL[i].ad;
         req_wdata = TBL[i].wd;
         act_valid = TBL[i].av;
         act_loc   = TBL[i].al;
         @(posedge clk);
         @(negedge clk);
         chk($sformatf("R10 vec %0d rsp_valid", i), 32'(rsp_valid), 32'h1);
         chk($sformatf("R%0d vec %0d rdata", TBL[i].rq, i), rsp_rdata, TBL[i].erd);
         chk($sformatf("R%0d vec %0d err", TBL[i].rq, i), 32'(rsp_err), 32'(TBL[i].eerr));
         chk($sformatf("R%0d vec %0d wr_valid", TBL[i].rq, i), 32'(wr_valid), 32'(TBL[i].ewv));
         if (TBL[i].ewv) begin
            chk($sformatf("R%0d vec %0d wr_reg", TBL[i].rq, i), 32'(wr_reg), 32'(TBL[i].ereg));
            chk($sformatf("R%0d vec %0d wr_data", TBL[i].rq, i), wr_data, TBL[i].ewd);
            chk($sformatf("R%0d vec %0d wr_be", TBL[i].rq, i), 32'(wr_be), 32'(TBL[i].ebe));
         end
      end

      // R10 idle cycle: no response, no strobe
      req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R10 idle rsp_valid", 32'(rsp_valid), 32'h0);
      chk("R10 idle wr_valid", 32'(wr_valid), 32'h0);

      // R1 combinational decode toward downstream
      req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 15'h2010;
      act_valid = 1'b0; act_loc = 3'd0;
      #1;
      chk("R1 dn_loc", 32'(dn_loc), 32'd2);
      chk("R1 dn_reg", 32'(dn_reg), 32'd3);
      @(posedge clk);
      @(negedge clk);
      chk("R4 intsts read ungated", rsp_rdata, 32'hC0DE0302);

      // R6 access write carries its locality, no active owner needed
      req_write = 1'b1; req_addr = 15'h3000; req_wdata = 32'h8;
      @(posedge clk);
      @(negedge clk);
      chk("R6 access wr_valid", 32'(wr_valid), 32'h1);
      chk("R6 access wr_loc", 32'(wr_loc), 32'd3);

      // R5 same offset from owner then from a non-owner, back to back
      req_addr = 15'h4018; act_valid = 1'b1; act_loc = 3'd4; req_wdata = 32'h40;
      @(posedge clk);
      @(negedge clk);
      chk("R5 owner status write", 32'(wr_valid), 32'h1);
      chk("R5 owner wr_loc", 32'(wr_loc), 32'd4);
      act_loc = 3'd0;
      @(posedge clk);
      @(negedge clk);
      chk("R5 non-owner status write", 32'(wr_valid), 32'h0);
      req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R10 final idle", 32'(rsp_valid), 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule